// File: doc/BRIEF.md
# Template-Driven Bundle Dispersal Unit

This unit sits between an instruction fetch buffer and the back-end pipelines of an in-order wide-issue core. Each cycle it looks at a window of two 128-bit bundles. Every bundle carries three instruction slots and a 5-bit template that fixes the pipeline class of each slot (memory, integer, floating point or branch) and where its instruction group ends. The unit walks the six slots in program order. It hands each slot a port of the required class, and it splits issue at the first slot that cannot go. A slot cannot go when a group stop lies before it, when it follows a serialising instruction, when its class is stalled, when its class has run out of ports, or when its bundle is absent or carries a reserved template.

The fetch buffer tells the unit how many slots at the front of the first bundle were already consumed, through a head offset. The unit returns per-slot grants, the class and port of each granted slot, and the number of slots consumed this cycle. The buffer then shifts by whole slots and refills a bundle once all three of its slots are gone. The decision is registered, so grants appear one clock after the window is presented.

Top module: `disp_unit`

## Requirements
- R1: A bundle holds its template in bits [4:0] and slot k (k = 0..2) in bits [5+41k +: 41]. Template bits [4:2] select the slot classes as (slot0, slot1, slot2): 0 = M,I,I; 1 = M,M,I; 2 = M,F,I; 3 = M,I,B; 4 = M,M,B; 5 = M,F,B; 6 = B,B,B. Code 7 is reserved. When nothing else blocks issue, all six window slots issue in one cycle.
- R2: Template bits [1:0] place a group stop: 0 means no stop, and n = 1..3 means a stop after slot n-1. No slot after a stop issues in the same cycle as the slot before it. A stop in a slot below the head offset has no effect.
- R3: Each class has a parameterised port count (defaults: memory 2, integer 2, floating point 1, branch 3). The first slot that finds its class already full is held, together with every later slot, while the slots before it issue.
- R4: Issue is strictly in order. The granted slots always form one contiguous run starting at the head offset.
- R5: cls_stall bits are indexed by class (bit 0 memory, 1 integer, 2 floating point, 3 branch). No slot issues at or after the first slot whose class is stalled.
- R6: A memory slot whose major opcode (bits [40:37] of the slot) equals SER_MAJOR (default 4'hE) is serialising. It may issue, but no later slot issues in the same cycle. The same opcode in a non-memory slot has no effect.
- R7: A valid bundle with a reserved template sets tmpl_bad. None of that bundle's slots issue, and nothing after it issues.
- R8: Within each class, granted slots receive ports 0, 1, 2, ... in slot order. iss_cls[2i +: 2] and iss_port[PW*i +: PW] report the class code and port of slot i, and are zero for slots that are not granted.
- R9: Slots below win_head are not issued. iss_cnt equals the number of slots granted this cycle (0 to 6).
- R10: Outputs are registered: they reflect the inputs at the previous rising clock edge and are all zero during reset. A bundle with win_vld low issues nothing and never raises tmpl_bad.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_bnd0 | input | 128 | Older bundle of the issue window |
| win_bnd1 | input | 128 | Younger bundle of the issue window |
| win_vld | input | 2 | Bundle present flags, bit b for bundle b |
| win_head | input | 2 | Number of leading slots of bundle 0 already consumed |
| cls_stall | input | 4 | Per-class stall, indexed by class code |
| iss_grant | output | 6 | Per-slot issue grant, bit i for window slot i |
| iss_cls | output | 12 | Class code of each granted slot, 2 bits per slot |
| iss_port | output | 6*PW | Port index of each granted slot, PW bits per slot (PW = 2 by default) |
| iss_cnt | output | 3 | Number of slots consumed this cycle |
| tmpl_bad | output | 1 | A valid bundle carries a reserved template |

## Verification
The assertions check the cycle-independent rules on every clock: the grants form one contiguous run, no class exceeds its port count, a stalled class receives no grant, slots below the head offset stay ungranted, the count matches the grants, and an empty window issues nothing. Only the bench scenarios can show that the issue point lands on the right slot for each template, stop position, serialising opcode and reserved code, and that the ports are numbered in slot order. They also show that a stop below the head offset and the serialising opcode in a non-memory slot are ignored.

// File: rtl/disp_pkg.sv
package disp_pkg;

    localparam int TMPL_W        = 5;
    localparam int SLOT_W        = 41;
    localparam int SLOTS_PER_BND = 3;
    localparam int N_BND         = 2;
    localparam int WIN_SLOTS     = SLOTS_PER_BND * N_BND;
    localparam int BND_W         = TMPL_W + SLOTS_PER_BND * SLOT_W;
    localparam int CNT_W         = $clog2(WIN_SLOTS + 1);
    localparam int N_CLS         = 4;
    localparam int MAJ_W         = 4;

    typedef enum logic [1:0] {
        CLS_MEM = 2'd0,
        CLS_INT = 2'd1,
        CLS_FP  = 2'd2,
        CLS_BR  = 2'd3
    } pclass_e;

    typedef struct packed {
        pclass_e cls;
        logic    stop_after;
        logic    serial;
    } slot_info_t;

    // Class layout per template kind, element k is slot k
    function automatic logic [SLOTS_PER_BND-1:0][1:0] slot_layout(input logic [2:0] kind);
        logic [SLOTS_PER_BND-1:0][1:0] l;
        case (kind)
            3'd0:    l = {CLS_INT, CLS_INT, CLS_MEM};
            3'd1:    l = {CLS_INT, CLS_MEM, CLS_MEM};
            3'd2:    l = {CLS_INT, CLS_FP,  CLS_MEM};
            3'd3:    l = {CLS_BR,  CLS_INT, CLS_MEM};
            3'd4:    l = {CLS_BR,  CLS_MEM, CLS_MEM};
            3'd5:    l = {CLS_BR,  CLS_FP,  CLS_MEM};
            3'd6:    l = {CLS_BR,  CLS_BR,  CLS_BR};
            default: l = {CLS_MEM, CLS_MEM, CLS_MEM};
        endcase
        return l;
    endfunction

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/disp_tmpl_dec.sv
module disp_tmpl_dec
    import disp_pkg::*;
#(
    parameter logic [MAJ_W-1:0] SER_MAJOR = 4'hE
) (
    input  logic [BND_W-1:0]                    bnd,
    output slot_info_t [SLOTS_PER_BND-1:0]      info,
    output logic                                bad
);

    logic [2:0]                    kind;
    logic [1:0]                    stp;
    logic [SLOTS_PER_BND-1:0][1:0] lay;

    assign kind = bnd[4:2];
    assign stp  = bnd[1:0];
    assign lay  = slot_layout(kind);
    assign bad  = (kind == 3'd7);

    for (genvar k = 0; k < SLOTS_PER_BND; k++) begin : g_slot
        localparam int MAJ_LSB = TMPL_W + k * SLOT_W + SLOT_W - MAJ_W;
        logic is_mem;
        logic maj_hit;
        assign is_mem  = (lay[k] == CLS_MEM);
        assign maj_hit = (bnd[MAJ_LSB +: MAJ_W] == SER_MAJOR);
        assign info[k] = '{
            cls:        pclass_e'(lay[k]),
            stop_after: (stp == 2'(k + 1)),
            serial:     is_mem && maj_hit
        };
    end

endmodule

// File: rtl/disp_issue_scan.sv
module disp_issue_scan
    import disp_pkg::*;
#(
    parameter int N_MEM = 2,
    parameter int N_INT = 2,
    parameter int N_FP  = 1,
    parameter int N_BR  = 3,
    parameter int PW    = 2
) (
    input  slot_info_t [WIN_SLOTS-1:0]          info,
    input  logic [N_BND-1:0]                    bvld,
    input  logic [N_BND-1:0]                    bbad,
    input  logic [1:0]                          head,
    input  logic [N_CLS-1:0]                    stall,
    output logic [WIN_SLOTS-1:0]                grant,
    output logic [WIN_SLOTS-1:0][PW-1:0]        port,
    output logic [CNT_W-1:0]                    cnt
);

    localparam int LIM [N_CLS] = '{N_MEM, N_INT, N_FP, N_BR};

    always_comb begin
        int         used [N_CLS];
        logic       go;
        logic [1:0] cidx;
        logic       bidx;
        grant = '0;
        port  = '0;
        cnt   = '0;
        go    = 1'b1;
        cidx  = '0;
        bidx  = 1'b0;
        for (int c = 0; c < N_CLS; c++) used[c] = 0;
        for (int i = 0; i < WIN_SLOTS; i++) begin
            cidx = info[i].cls;
            bidx = (i >= SLOTS_PER_BND);
            if (go && (i >= int'(head))) begin
                if (!bvld[bidx] || bbad[bidx] || stall[cidx] || (used[cidx] >= LIM[cidx])) begin
                    go = 1'b0;
                end else begin
                    grant[i]   = 1'b1;
                    port[i]    = PW'(used[cidx]);
                    used[cidx] = used[cidx] + 1;
                    cnt        = cnt + CNT_W'(1);
                    if (info[i].stop_after || info[i].serial) go = 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/disp_unit.sv
module disp_unit
    import disp_pkg::*;
#(
    parameter int               N_MEM     = 2,
    parameter int               N_INT     = 2,
    parameter int               N_FP      = 1,
    parameter int               N_BR      = 3,
    parameter logic [MAJ_W-1:0] SER_MAJOR = 4'hE,
    localparam int              MAXP      = max4(N_MEM, N_INT, N_FP, N_BR),
    localparam int              PW        = (MAXP > 1) ? $clog2(MAXP) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [BND_W-1:0]          win_bnd0,
    input  logic [BND_W-1:0]          win_bnd1,
    input  logic [N_BND-1:0]          win_vld,
    input  logic [1:0]                win_head,
    input  logic [N_CLS-1:0]          cls_stall,
    output logic [WIN_SLOTS-1:0]      iss_grant,
    output logic [2*WIN_SLOTS-1:0]    iss_cls,
    output logic [PW*WIN_SLOTS-1:0]   iss_port,
    output logic [CNT_W-1:0]          iss_cnt,
    output logic                      tmpl_bad
);

    typedef struct packed {
        logic [WIN_SLOTS-1:0]    grant;
        logic [2*WIN_SLOTS-1:0]  cls;
        logic [PW*WIN_SLOTS-1:0] port;
        logic [CNT_W-1:0]        cnt;
        logic                    bad;
    } disp_out_t;

    logic [N_BND-1:0][BND_W-1:0]    bnds;
    slot_info_t [WIN_SLOTS-1:0]     info;
    logic [N_BND-1:0]               bbad;
    logic [WIN_SLOTS-1:0]           sc_grant;
    logic [WIN_SLOTS-1:0][PW-1:0]   sc_port;
    logic [CNT_W-1:0]               sc_cnt;
    disp_out_t                      out_d;
    disp_out_t                      out_q;

    assign bnds = {win_bnd1, win_bnd0};

    for (genvar b = 0; b < N_BND; b++) begin : g_dec
        disp_tmpl_dec #(
            .SER_MAJOR (SER_MAJOR)
        ) u_dec (
            .bnd  (bnds[b]),
            .info (info[b*SLOTS_PER_BND +: SLOTS_PER_BND]),
            .bad  (bbad[b])
        );
    end

    disp_issue_scan #(
        .N_MEM (N_MEM),
        .N_INT (N_INT),
        .N_FP  (N_FP),
        .N_BR  (N_BR),
        .PW    (PW)
    ) u_scan (
        .info  (info),
        .bvld  (win_vld),
        .bbad  (bbad),
        .head  (win_head),
        .stall (cls_stall),
        .grant (sc_grant),
        .port  (sc_port),
        .cnt   (sc_cnt)
    );

    always_comb begin
        out_d       = '0;
        out_d.grant = sc_grant;
        out_d.port  = sc_port;
        out_d.cnt   = sc_cnt;
        out_d.bad   = |(win_vld & bbad);
        for (int i = 0; i < WIN_SLOTS; i++) begin
            out_d.cls[2*i +: 2] = sc_grant[i] ? info[i].cls : 2'b00;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign iss_grant = out_q.grant;
    assign iss_cls   = out_q.cls;
    assign iss_port  = out_q.port;
    assign iss_cnt   = out_q.cnt;
    assign tmpl_bad  = out_q.bad;

endmodule

// File: rtl/disp_unit_chk.sv
module disp_unit_chk #(
    parameter int N_MEM = 2,
    parameter int N_INT = 2,
    parameter int N_FP  = 1,
    parameter int N_BR  = 3,
    parameter int PW    = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        win_vld,
    input logic [1:0]        win_head,
    input logic [3:0]        cls_stall,
    input logic [5:0]        iss_grant,
    input logic [11:0]       iss_cls,
    input logic [PW*6-1:0]   iss_port,
    input logic [2:0]        iss_cnt,
    input logic              tmpl_bad
);

    logic [6:0] gx;
    int         n_cls [4];
    logic [3:0] cls_hit;
    logic       port_seen;

    assign gx = {1'b0, iss_grant} | ({1'b0, iss_grant} - 7'd1);
    assign port_seen = |iss_port;

    always_comb begin
        cls_hit = '0;
        for (int c = 0; c < 4; c++) n_cls[c] = 0;
        for (int i = 0; i < 6; i++) begin
            for (int c = 0; c < 4; c++) begin
                if (iss_grant[i] && (iss_cls[2*i +: 2] == 2'(c))) begin
                    n_cls[c]   = n_cls[c] + 1;
                    cls_hit[c] = 1'b1;
                end
            end
        end
    end

    // R4
    contig_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((gx & (gx + 7'd1)) == 7'd0));

    // R3
    port_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (n_cls[0] <= N_MEM) && (n_cls[1] <= N_INT) && (n_cls[2] <= N_FP) && (n_cls[3] <= N_BR));

    // R5
    stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_stall != 4'd0) |=> ((cls_hit & $past(cls_stall)) == 4'd0));

    // R10
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_vld == 2'd0) |=> ((iss_grant == 6'd0) && (iss_cnt == 3'd0) && !tmpl_bad && !port_seen));

    // R9
    head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_head != 2'd0) |=> ((iss_grant & 6'((7'd1 << $past(win_head)) - 7'd1)) == 6'd0));

    // R9
    cnt_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_cnt == 3'($countones(iss_grant))));

endmodule

bind disp_unit disp_unit_chk #(
    .N_MEM (N_MEM),
    .N_INT (N_INT),
    .N_FP  (N_FP),
    .N_BR  (N_BR),
    .PW    (PW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .win_vld   (win_vld),
    .win_head  (win_head),
    .cls_stall (cls_stall),
    .iss_grant (iss_grant),
    .iss_cls   (iss_cls),
    .iss_port  (iss_port),
    .iss_cnt   (iss_cnt),
    .tmpl_bad  (tmpl_bad)
);

// File: tb/disp_unit_tb.sv
`timescale 1ns/1ps
module disp_unit_tb;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [127:0]  win_bnd0, win_bnd1;
    logic [1:0]    win_vld;
    logic [1:0]    win_head;
    logic [3:0]    cls_stall;
    logic [5:0]    iss_grant;
    logic [11:0]   iss_cls;
    logic [11:0]   iss_port;
    logic [2:0]    iss_cnt;
    logic          tmpl_bad;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    disp_unit u_dut (
        .clk(clk), .rst_n(rst_n), .win_bnd0(win_bnd0), .win_bnd1(win_bnd1),
        .win_vld(win_vld), .win_head(win_head), .cls_stall(cls_stall),
        .iss_grant(iss_grant), .iss_cls(iss_cls), .iss_port(iss_port),
        .iss_cnt(iss_cnt), .tmpl_bad(tmpl_bad)
    );

    typedef struct packed {
        logic [3:0] req;
        logic [1:0] vld;
        logic [4:0] t0;
        logic [4:0] t1;
        logic [1:0] head;
        logic [3:0] stall;
        logic [5:0] ser;
        logic [5:0] g;
        logic [2:0] cnt;
        logic       bad;
    } vec_t;

    localparam int NV = 20;
    // template code = {kind[2:0], stop[1:0]}; stall bits: 0 M, 1 I, 2 F, 3 B
    localparam vec_t VECS [NV] = '{
        '{4'd3,  2'b11, 5'd0,  5'd0,  2'd0, 4'h0, 6'h00, 6'b001111, 3'd4, 1'b0}, // R3 int ports full
        '{4'd3,  2'b11, 5'd8,  5'd20, 2'd0, 4'h0, 6'h00, 6'b001111, 3'd4, 1'b0}, // R3 fp port full
        '{4'd3,  2'b11, 5'd16, 5'd24, 2'd0, 4'h0, 6'h00, 6'b011111, 3'd5, 1'b0}, // R3 branch ports full
        '{4'd1,  2'b11, 5'd12, 5'd20, 2'd0, 4'h0, 6'h00, 6'b111111, 3'd6, 1'b0}, // R1 full window
        '{4'd2,  2'b11, 5'd2,  5'd0,  2'd0, 4'h0, 6'h00, 6'b000011, 3'd2, 1'b0}, // R2 stop after slot1
        '{4'd2,  2'b11, 5'd3,  5'd12, 2'd0, 4'h0, 6'h00, 6'b000111, 3'd3, 1'b0}, // R2 stop at bundle end
        '{4'd2,  2'b11, 5'd1,  5'd12, 2'd0, 4'h0, 6'h00, 6'b000001, 3'd1, 1'b0}, // R2 stop after slot0
        '{4'd2,  2'b11, 5'd12, 5'd13, 2'd0, 4'h0, 6'h00, 6'b001111, 3'd4, 1'b0}, // R2 stop in bundle1
        '{4'd5,  2'b11, 5'd12, 5'd12, 2'd0, 4'h2, 6'h00, 6'b000001, 3'd1, 1'b0}, // R5 int stalled
        '{4'd5,  2'b11, 5'd12, 5'd12, 2'd0, 4'h8, 6'h00, 6'b000011, 3'd2, 1'b0}, // R5 branch stalled
        '{4'd6,  2'b11, 5'd4,  5'd0,  2'd0, 4'h0, 6'h01, 6'b000001, 3'd1, 1'b0}, // R6 serial mem slot
        '{4'd6,  2'b11, 5'd12, 5'd20, 2'd0, 4'h0, 6'h02, 6'b111111, 3'd6, 1'b0}, // R6 opcode on int slot
        '{4'd7,  2'b11, 5'd28, 5'd0,  2'd0, 4'h0, 6'h00, 6'b000000, 3'd0, 1'b1}, // R7 bundle0 reserved
        '{4'd7,  2'b11, 5'd12, 5'd30, 2'd0, 4'h0, 6'h00, 6'b000111, 3'd3, 1'b1}, // R7 bundle1 reserved
        '{4'd10, 2'b01, 5'd12, 5'd0,  2'd0, 4'h0, 6'h00, 6'b000111, 3'd3, 1'b0}, // R10 bundle1 absent
        '{4'd10, 2'b00, 5'd28, 5'd0,  2'd0, 4'h0, 6'h00, 6'b000000, 3'd0, 1'b0}, // R10 empty window
        '{4'd9,  2'b11, 5'd12, 5'd12, 2'd2, 4'h0, 6'h00, 6'b111100, 3'd4, 1'b0}, // R9 head 2
        '{4'd9,  2'b11, 5'd4,  5'd4,  2'd1, 4'h0, 6'h00, 6'b001110, 3'd3, 1'b0}, // R9 head 1, mem full
        '{4'd2,  2'b11, 5'd14, 5'd12, 2'd2, 4'h0, 6'h00, 6'b111100, 3'd4, 1'b0}, // R2 stop below head
        '{4'd6,  2'b11, 5'd12, 5'd4,  2'd0, 4'h0, 6'h08, 6'b001111, 3'd4, 1'b0}  // R6 serial in bundle1
    };

    function automatic logic [127:0] mk_bnd(input logic [4:0] t, input logic [2:0] ser);
        logic [2:0][40:0] s;
        for (int k = 0; k < 3; k++) s[k] = ser[k] ? {4'hE, 37'h0_1234_5678} : {4'h3, 37'h0_0000_0ABC};
        return {s, t};
    endfunction

    task automatic chk(input string what, input int req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        win_bnd0  = mk_bnd(v.t0, v.ser[2:0]);
        win_bnd1  = mk_bnd(v.t1, v.ser[5:3]);
        win_vld   = v.vld;
        win_head  = v.head;
        cls_stall = v.stall;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 100000 && !done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: cycles %0d expected below %0d", cyc, 100000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        drive(VECS[3]);
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("reset grant", 10, 32'(iss_grant), 32'd0);
        chk("reset cnt",   10, 32'(iss_cnt),   32'd0);
        chk("reset bad",   10, 32'(tmpl_bad),  32'd0);
        chk("reset cls",   10, 32'(iss_cls),   32'd0);
        rst_n = 1'b1;

        for (int n = 0; n < NV; n++) begin
            @(negedge clk);
            drive(VECS[n]);
            @(negedge clk);
            chk($sformatf("vec%0d grant", n), int'(VECS[n].req), 32'(iss_grant), 32'(VECS[n].g));
            chk($sformatf("vec%0d cnt",   n), int'(VECS[n].req), 32'(iss_cnt),   32'(VECS[n].cnt));
            chk($sformatf("vec%0d bad",   n), int'(VECS[n].req), 32'(tmpl_bad),  32'(VECS[n].bad));
        end

        // R8: classes and ports for M I B | M F B
        @(negedge clk);
        drive(VECS[3]);
        @(negedge clk);
        chk("cls full window",  8, 32'(iss_cls),  32'({2'd3, 2'd2, 2'd0, 2'd3, 2'd1, 2'd0}));
        chk("port full window", 8, 32'(iss_port), 32'({2'd1, 2'd0, 2'd1, 2'd0, 2'd0, 2'd0}));

        // R8: I I split: slot3 memory gets port 1, int slots ports 0 and 1
        drive(VECS[0]);
        @(negedge clk);
        chk("cls int split",  8, 32'(iss_cls),  32'({2'd0, 2'd0, 2'd0, 2'd1, 2'd1, 2'd0}));
        chk("port int split", 8, 32'(iss_port), 32'({2'd0, 2'd0, 2'd1, 2'd1, 2'd0, 2'd0}));

        // R8: ungranted slots report zero class and port (B B B after head 0 stop)
        drive('{4'd8, 2'b11, 5'd25, 5'd24, 2'd0, 4'h0, 6'h00, 6'b000001, 3'd1, 1'b0});
        @(negedge clk);
        chk("cls only slot0",  8, 32'(iss_cls),  32'({10'd0, 2'd3}));
        chk("port only slot0", 8, 32'(iss_port), 32'd0);

        // R10: one-cycle latency, output holds until the next rising edge
        drive(VECS[0]);
        @(negedge clk);
        chk("cnt before change", 10, 32'(iss_cnt), 32'd4);
        drive(VECS[3]);
        #5;
        chk("cnt held before edge", 10, 32'(iss_cnt), 32'd4);
        @(negedge clk);
        chk("cnt after edge", 10, 32'(iss_cnt), 32'd6);

        // R5: stall on fp lifted lets the full window through again
        drive('{4'd5, 2'b11, 5'd12, 5'd20, 2'd0, 4'h4, 6'h00, 6'b001111, 3'd4, 1'b0});
        @(negedge clk);
        chk("fp stalled grant", 5, 32'(iss_grant), 32'b001111);
        cls_stall = 4'h0;
        @(negedge clk);
        chk("fp released grant", 5, 32'(iss_grant), 32'b111111);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule